// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block sits between a conversion sequencer and a host. Each result the sequencer produces is a 13-bit two's-complement value. It comes with the 3-bit index of the sequencer instruction that made it. The block turns each result into a 16-bit word and queues it in a 32-entry first-in first-out store. The host pops words one at a time.

The upper three bits of each word depend on a mask control input, which is sampled when the result is written:
- mask low: the bits carry the instruction index;
- mask high: the bits repeat the sign bit, so the word reads as a sign-extended 16-bit number.

The host sees the current occupancy. It also sets a fill threshold. A registered interrupt request stays high while the occupancy equals that threshold. A push that finds the store full is dropped and sets a sticky overflow flag.

Top module: `tagged_result_fifo`

## Requirements
- R1: After a synchronous active-low reset, fill_level is 0, pop_word is 0, fill_irq is 0 and ovf_flag is 0.
- R2: With tag_mask low at write time, the stored word has res_tag in bits 15:13 and res_data in bits 12:0.
- R3: With tag_mask high at write time, bits 15:13 of the stored word all equal bit 12 of res_data, and bits 12:0 equal res_data.
- R4: tag_mask is sampled only in the cycle a result is pushed; changing it later leaves words already stored unchanged.
- R5: Words leave in the order they were pushed. A pop request loads pop_word at the next clock edge, and pop_word holds until the next pop request.
- R6: fill_level equals the number of stored words and changes at the clock edge after a push or pop. An accepted push and an accepted pop in the same cycle leave it unchanged.
- R7: The store holds at most 32 words. A push while fill_level is 32 is dropped, even if a pop occurs in the same cycle, and sets ovf_flag, which stays set until reset.
- R8: A pop request while fill_level is 0 loads 0 into pop_word and leaves the count unchanged. A push in the same cycle is still accepted, so the count becomes 1.
- R9: fill_irq is registered. It is 1 in the cycle after an edge at which the updated count equals a nonzero fill_thresh. It is 0 otherwise, and always 0 while fill_thresh is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Push request for a new conversion result |
| res_data | input | 13 | Two's-complement conversion result, bit 12 is the sign |
| res_tag | input | 3 | Index of the instruction that produced the result |
| tag_mask | input | 1 | 1: sign-extend the upper bits; 0: place the tag in the upper bits |
| pop_req | input | 1 | Host pop request |
| pop_word | output | 16 | Word returned by the last pop |
| fill_level | output | 6 | Number of words stored (0 to 32) |
| fill_thresh | input | 6 | Occupancy at which fill_irq is raised; 0 disables it |
| fill_irq | output | 1 | Fill-level interrupt request |
| ovf_flag | output | 1 | Sticky flag for a push dropped while full |

## Verification
Push and pop can fall in the same cycle, and how they combine depends on the occupancy:
- partly filled store: both are accepted and the count stays the same;
- empty store: the push lands but the pop returns zero;
- full store: the pop is served but the push is dropped and flags overflow.

The vector table and the directed tests drive both requests in one cycle at each of these three levels. They then judge the popped word, the count and the overflow flag one edge later. They also follow the queue through later pops, which shows that the dropped word never entered it. The threshold compare runs on the updated count, so it is checked in the same passes.

// File: rtl/trf_pkg.sv
// Package: shared widths and the stored word layout for the result FIFO.
// Assumes the result is 13-bit two's complement with a 3-bit instruction tag.
package trf_pkg;
    localparam int DATA_W = 13;
    localparam int TAG_W  = 3;
    localparam int WORD_W = DATA_W + TAG_W;

    typedef struct packed {
        logic [TAG_W-1:0]  upper;
        logic [DATA_W-1:0] data;
    } word_t;
endpackage

// File: rtl/trf_format.sv
// Module: builds the 16-bit stored word from a result, its tag and the mask.
// Assumes it is purely combinational; the caller samples the output on push.
module trf_format
    import trf_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              mask_i,
    output word_t             word_o
);
    // Select upper bits: sign copies when masked, the tag otherwise.
    always_comb begin
        word_o.data  = data_i;
        word_o.upper = mask_i ? {TAG_W{data_i[DATA_W-1]}} : tag_i;
    end
endmodule

// File: rtl/trf_store.sv
// Module: circular word storage with write/read pointers and a registered
// read port. Assumes push_i/pop_i are already qualified against full/empty.
module trf_store
    import trf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  logic  pop_i,
    input  logic  rd_req_i,
    input  word_t wdata_i,
    output word_t rdata_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    // Next-pointer helper with explicit wrap for any depth.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write an accepted word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_i) mem[wptr] <= wdata_i;
    end

    // Advance pointers on accepted push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push_i) wptr <= bump(wptr);
            if (pop_i)  rptr <= bump(rptr);
        end
    end

    // Load the read register on any pop request; zero when nothing to pop.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_o <= '0;
        else if (rd_req_i) rdata_o <= pop_i ? mem[rptr] : '0;
    end

    // R8: a request that could not pop returns zero on the next cycle.
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !pop_i) |=> (rdata_o == '0));

    // R5: without a request the read register holds its value.
    assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> $stable(rdata_o));
endmodule

// File: rtl/trf_level.sv
// Module: occupancy counter, push/pop qualification, sticky overflow and
// the registered threshold compare. Assumes requests are single-cycle levels.
module trf_level #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req_i,
    input  logic             rd_req_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             push_ok_o,
    output logic             pop_ok_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic             is_full;
    logic             is_empty;
    logic [CNT_W-1:0] cnt_nxt;

    // Qualify requests against the count at the start of the cycle.
    always_comb begin
        is_full   = (count_o == FULL_CNT);
        is_empty  = (count_o == '0);
        push_ok_o = wr_req_i && !is_full;
        pop_ok_o  = rd_req_i && !is_empty;
        cnt_nxt   = count_o + CNT_W'(push_ok_o) - CNT_W'(pop_ok_o);
    end

    // Update count, sticky overflow and threshold request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            count_o <= cnt_nxt;
            ovf_o   <= ovf_o | (wr_req_i && is_full);
            irq_o   <= (thresh_i != '0) && (cnt_nxt == thresh_i);
        end
    end

    // R7: occupancy never exceeds the depth.
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL_CNT);

    // R7: overflow stays set once raised.
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R7: push into a full store without a pop leaves it full and flags it.
    assert_full_push_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && is_full && !rd_req_i) |=> (count_o == FULL_CNT) && ovf_o);

    // R8: pop on empty without a push keeps the count at zero.
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && is_empty && !wr_req_i) |=> (count_o == '0));

    // R9: a raised request always matches the threshold seen at the edge.
    assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (count_o == $past(thresh_i)) && (count_o != '0));
endmodule

// File: rtl/tagged_result_fifo.sv
// Module: top of the tagged conversion result FIFO. Formats each result,
// stores it, tracks occupancy and raises the fill request.
// Assumes one result per cycle at most and a single host reader.
module tagged_result_fifo
    import trf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              tag_mask,
    input  logic              pop_req,
    output logic [WORD_W-1:0] pop_word,
    output logic [CNT_W-1:0]  fill_level,
    input  logic [CNT_W-1:0]  fill_thresh,
    output logic              fill_irq,
    output logic              ovf_flag
);
    word_t fmt_word;
    word_t rd_word;
    logic  push_ok;
    logic  pop_ok;

    trf_format u_fmt (
        .data_i (res_data),
        .tag_i  (res_tag),
        .mask_i (tag_mask),
        .word_o (fmt_word)
    );

    trf_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req_i  (res_valid),
        .rd_req_i  (pop_req),
        .thresh_i  (fill_thresh),
        .push_ok_o (push_ok),
        .pop_ok_o  (pop_ok),
        .count_o   (fill_level),
        .ovf_o     (ovf_flag),
        .irq_o     (fill_irq)
    );

    trf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_ok),
        .pop_i    (pop_ok),
        .rd_req_i (pop_req),
        .wdata_i  (fmt_word),
        .rdata_o  (rd_word)
    );

    // Expose the read register as a flat word.
    always_comb pop_word = rd_word;

    // R3: a masked push stores a word whose upper bits match the sign.
    assert_mask_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && tag_mask) |-> (u_store.wdata_i.upper == {TAG_W{res_data[DATA_W-1]}}));
endmodule

// File: tb/tagged_result_fifo_test.sv
// Bench: vector table walk followed by directed reset and corner tests.
module tagged_result_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [12:0] res_data;
    logic [2:0]  res_tag;
    logic        tag_mask;
    logic        pop_req;
    logic [15:0] pop_word;
    logic [5:0]  fill_level;
    logic [5:0]  fill_thresh;
    logic        fill_irq;
    logic        ovf_flag;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tagged_result_fifo uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_tag(res_tag), .tag_mask(tag_mask), .pop_req(pop_req),
        .pop_word(pop_word), .fill_level(fill_level), .fill_thresh(fill_thresh),
        .fill_irq(fill_irq), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        mask;
        logic [2:0]  tag;
        logic [12:0] data;
        logic [5:0]  exp_cnt;
        logic [15:0] exp_rd;
    } vec_t;

    // Threshold is 2 during the table; rd words checked only when rd=1.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 3'd5, 13'h0ABC, 6'd1, 16'h0000},  // R2 tag in upper bits
        '{1'b1, 1'b0, 1'b1, 3'd6, 13'h1234, 6'd2, 16'h0000},  // R3 negative sign fill
        '{1'b1, 1'b0, 1'b1, 3'd2, 13'h0567, 6'd3, 16'h0000},  // R3 positive sign fill
        '{1'b0, 1'b1, 1'b1, 3'd0, 13'h0000, 6'd2, 16'hAABC},  // R4 mask changed since
        '{1'b1, 1'b1, 1'b0, 3'd3, 13'h1FFF, 6'd2, 16'hF234},  // R6 push+pop
        '{1'b0, 1'b1, 1'b0, 3'd0, 13'h0000, 6'd1, 16'h0567},  // R5 order
        '{1'b0, 1'b1, 1'b0, 3'd0, 13'h0000, 6'd0, 16'h7FFF},  // R2 tag 3
        '{1'b0, 1'b1, 1'b0, 3'd0, 13'h0000, 6'd0, 16'h0000},  // R8 empty pop
        '{1'b1, 1'b1, 1'b0, 3'd7, 13'h1000, 6'd1, 16'h0000},  // R8 push+pop empty
        '{1'b0, 1'b1, 1'b0, 3'd0, 13'h0000, 6'd0, 16'hF000}   // R5 pushed word
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; returns at the next one.
    task automatic cyc(input logic wr, input logic rd, input logic mk,
                       input logic [2:0] tg, input logic [12:0] dt);
        res_valid = wr; pop_req = rd; tag_mask = mk; res_tag = tg; res_data = dt;
        @(negedge clk);
        res_valid = 1'b0; pop_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        res_valid = 1'b0; pop_req = 1'b0; tag_mask = 1'b0;
        res_tag = '0; res_data = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        fill_thresh = 6'd2;
        @(negedge clk);
        do_reset();
        check("R1 level", {10'd0, fill_level}, 16'd0);
        check("R1 word", pop_word, 16'd0);
        check("R1 irq", {15'd0, fill_irq}, 16'd0);
        check("R1 ovf", {15'd0, ovf_flag}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].wr, VECS[i].rd, VECS[i].mask, VECS[i].tag, VECS[i].data);
            check("R6 level", {10'd0, fill_level}, {10'd0, VECS[i].exp_cnt});
            if (VECS[i].rd) check("R5 word", pop_word, VECS[i].exp_rd);
            check("R9 irq", {15'd0, fill_irq}, {15'd0, VECS[i].exp_cnt == 6'd2});
        end
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 13'd0);
        check("R5 hold", pop_word, 16'hF000);

        // Fill to the depth with threshold 5.
        do_reset();
        fill_thresh = 6'd5;
        for (int i = 0; i < 32; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 3'(i % 8), 13'(i));
            if (i == 4) check("R9 irq at thresh", {15'd0, fill_irq}, 16'd1);
            if (i == 5) check("R9 irq past thresh", {15'd0, fill_irq}, 16'd0);
        end
        check("R7 full level", {10'd0, fill_level}, 16'd32);
        check("R7 no ovf yet", {15'd0, ovf_flag}, 16'd0);
        cyc(1'b1, 1'b0, 1'b1, 3'd1, 13'h0AAA);
        check("R7 push dropped", {10'd0, fill_level}, 16'd32);
        check("R7 ovf set", {15'd0, ovf_flag}, 16'd1);
        cyc(1'b1, 1'b1, 1'b0, 3'd2, 13'h0555);
        check("R7 push+pop full level", {10'd0, fill_level}, 16'd31);
        check("R7 push+pop full word", pop_word, 16'h0000);
        begin
            logic [15:0] last;
            last = '0;
            for (int i = 1; i < 32; i++) begin
                cyc(1'b0, 1'b1, 1'b0, 3'd0, 13'd0);
                last = pop_word;
                if (i == 9) check("R2 mid order", pop_word, 16'h2009);
            end
            check("R7 last word kept", last, 16'hE01F);
        end
        check("R7 drained", {10'd0, fill_level}, 16'd0);
        check("R7 ovf sticky", {15'd0, ovf_flag}, 16'd1);

        fill_thresh = 6'd0;
        cyc(1'b0, 1'b1, 1'b0, 3'd0, 13'd0);
        check("R9 zero thresh", {15'd0, fill_irq}, 16'd0);
        check("R8 empty level", {10'd0, fill_level}, 16'd0);

        do_reset();
        check("R1 ovf cleared", {15'd0, ovf_flag}, 16'd0);
        finish_run();
    end
endmodule